// File: doc/BRIEF.md
# Programmable Chip-Select Decoder

This block turns the address of a bus cycle into ten active-low chip selects: one upper region, one lower region and eight generic regions. Each region is bounded by a base and an end held in its own pair of registers. Both bounds are kept at 1 KB granularity. The block enables a region, picks its address space and sets its wait behaviour. If several regions match, the block asserts only the one with the lowest index.

The block also gives the bus controller a merged ready. If the winning region ignores the external ready, the block counts off the programmed number of wait clocks and then ends the cycle by itself. Otherwise the external ready passes straight through. Each generic pin can carry its chip select or a bit of an output latch, as chosen per pin.

Software programs the block through a one-cycle write port. A bus cycle is any run of cycles with `addr_vld` high.

Top module: `csd_decoder`

## Requirements
- R1: A write with `wr_en` high updates one register at the next clock edge. `wr_addr` = 2*k selects the start register of region k and 2*k+1 its stop register. Region 0 is upper, region 1 is lower and region 2+g is generic g. Address 20 is the pin-select mask and address 21 is the output latch, both in `wr_data[7:0]`.
- R2: Start register layout: bits 15:6 hold the base block (address bits 19:10), bit 4 is ready-ignore and bits 3:0 are the wait count. Stop register layout: bits 15:6 hold the end block, bit 1 is enable and bit 0 is the space select (1 means I/O).
- R3: A region matches when base <= addr[19:10] < end. An end field of 0 stands for the end of the address space, so a region can reach 0xFFFFF.
- R4: The upper and lower regions match memory cycles only, whatever bit 0 of their stop register holds. A generic region matches only the space that bit 0 selects.
- R5: After reset the upper region is enabled for memory cycles from 0xFFC00 to 0xFFFFF, with wait count 3 and ready-ignore clear. The lower and generic regions are disabled, the pin-select mask is 0 and the output latch is all ones.
- R6: While `addr_vld` is low, no chip select is asserted.
- R7: At most one chip select is asserted in any cycle.
- R8: When several enabled regions match, only the one with the lowest region index is asserted.
- R9: Generic pin g shows its chip select when bit g of the pin-select mask is 1. When that bit is 0 it shows bit g of the output latch.
- R10: When the winning region has ready-ignore set and wait count N, `ready_out` is low for the first N cycles of the bus cycle. From cycle N+1 onwards it is high while the cycle lasts, whatever `ext_ready` is. With N = 0 it is high in the first cycle.
- R11: When no region wins, or the winner has ready-ignore clear, `ready_out` equals `ext_ready`.
- R12: A bus cycle starts in any cycle where `addr_vld` is high after a low cycle, and the wait count reloads there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register select |
| wr_data | input | 16 | Register write data |
| addr_vld | input | 1 | Address phase valid; high for the whole bus cycle |
| addr | input | 20 | Bus address |
| is_io | input | 1 | 1 for an I/O-space cycle, 0 for memory |
| ext_ready | input | 1 | External ready |
| ucs_n | output | 1 | Upper chip select, active low |
| lcs_n | output | 1 | Lower chip select, active low |
| gcs_n | output | 8 | Generic pins: chip select or latch bit |
| ready_out | output | 1 | Merged ready to the bus controller |

## Verification
The assertions assume that `addr_vld` stays low for at least one cycle between bus cycles. They also assume that `addr` and `is_io` stay stable while `addr_vld` is high, and that no register write happens during a bus cycle. The stimulus respects all three. It writes only while the bus is idle, drives each random bus cycle for exactly one cycle followed by an idle cycle, and holds the address steady through the long directed wait-state cycles.

// File: rtl/csd_pkg.sv
package csd_pkg;
  localparam int RGN_UPPER   = 0;
  localparam int RGN_LOWER   = 1;
  localparam int RGN_GEN0    = 2;
  localparam int STOP_IO_BIT = 0;
  localparam int STOP_EN_BIT = 1;

  // half-open window test; an end of zero means "past the top block"
  function automatic logic in_window(input int unsigned blk, input int unsigned lo,
                                     input int unsigned hi, input int unsigned span);
    int unsigned top;
    top = (hi == 0) ? span : hi;
    return (blk >= lo) && (blk < top);
  endfunction
endpackage

// File: rtl/csd_regs.sv
module csd_regs import csd_pkg::*; #(
  parameter int NREG = 10,
  parameter int NUM_GEN = 8,
  parameter int REG_W = 16,
  parameter int BLK_W = 10,
  parameter int WAIT_W = 4,
  parameter int ADR_W = 5,
  parameter int UCS_RST_WAIT = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [ADR_W-1:0]             wr_addr,
  input  logic [REG_W-1:0]             wr_data,
  output logic [NREG-1:0][BLK_W-1:0]   base_q,
  output logic [NREG-1:0][BLK_W-1:0]   end_q,
  output logic [NREG-1:0][WAIT_W-1:0]  wait_q,
  output logic [NREG-1:0]              ign_q,
  output logic [NREG-1:0]              en_q,
  output logic [NREG-1:0]              io_q,
  output logic [NUM_GEN-1:0]           pin_en_q,
  output logic [NUM_GEN-1:0]           port_latch_q
);
  localparam int PIN_EN_ADR  = 2 * NREG;
  localparam int PIN_LAT_ADR = 2 * NREG + 1;
  localparam int IGN_BIT     = WAIT_W;

  logic wr_data_unused;
  assign wr_data_unused = ^wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NREG; r++) begin
        base_q[r] <= (r == RGN_UPPER) ? '1 : '0;
        end_q[r]  <= '0;
        wait_q[r] <= (r == RGN_UPPER) ? WAIT_W'(UCS_RST_WAIT) : '0;
        ign_q[r]  <= 1'b0;
        en_q[r]   <= (r == RGN_UPPER);
        io_q[r]   <= 1'b0;
      end
      pin_en_q     <= '0;
      port_latch_q <= '1;
    end else if (wr_en) begin
      for (int r = 0; r < NREG; r++) begin
        if (wr_addr == ADR_W'(2 * r)) begin
          base_q[r] <= wr_data[REG_W-1 -: BLK_W];
          ign_q[r]  <= wr_data[IGN_BIT];
          wait_q[r] <= wr_data[WAIT_W-1:0];
        end
        if (wr_addr == ADR_W'(2 * r + 1)) begin
          end_q[r] <= wr_data[REG_W-1 -: BLK_W];
          en_q[r]  <= wr_data[STOP_EN_BIT];
          io_q[r]  <= wr_data[STOP_IO_BIT];
        end
      end
      if (wr_addr == ADR_W'(PIN_EN_ADR))  pin_en_q     <= wr_data[NUM_GEN-1:0];
      if (wr_addr == ADR_W'(PIN_LAT_ADR)) port_latch_q <= wr_data[NUM_GEN-1:0];
    end
  end
endmodule

// File: rtl/csd_match.sv
module csd_match import csd_pkg::*; #(
  parameter int NREG = 10,
  parameter int BLK_W = 10
) (
  input  logic [BLK_W-1:0]             addr_blk,
  input  logic                         is_io,
  input  logic [NREG-1:0][BLK_W-1:0]   base_q,
  input  logic [NREG-1:0][BLK_W-1:0]   end_q,
  input  logic [NREG-1:0]              en_q,
  input  logic [NREG-1:0]              io_q,
  output logic [NREG-1:0]              hit
);
  localparam int unsigned SPAN = 1 << BLK_W;

  logic fixed_space_unused;
  assign fixed_space_unused = ^io_q[RGN_GEN0-1:0];

  for (genvar r = 0; r < NREG; r++) begin : g_cmp
    logic space_ok;
    if (r < RGN_GEN0) begin : g_mem_only
      assign space_ok = !is_io;
    end else begin : g_prog_space
      assign space_ok = (is_io == io_q[r]);
    end
    assign hit[r] = en_q[r] && space_ok &&
                    in_window(32'(addr_blk), 32'(base_q[r]), 32'(end_q[r]), SPAN);
  end
endmodule

// File: rtl/csd_prio.sv
module csd_prio #(
  parameter int N = 10,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = IDX_W'(i);
        any = 1'b1;
      end
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_grant
    assign grant[k] = any && (idx == IDX_W'(k));
  end
endmodule

// File: rtl/csd_wait.sv
module csd_wait #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_vld,
  input  logic              win_ign,
  input  logic [WAIT_W-1:0] win_wait,
  input  logic              ext_ready,
  output logic              ready_out
);
  logic              vld_q;
  logic [WAIT_W-1:0] cnt_q;
  logic [WAIT_W-1:0] left;
  logic              cycle_start;

  function automatic logic [WAIT_W-1:0] step_down(input logic [WAIT_W-1:0] v);
    return (v == '0) ? '0 : v - WAIT_W'(1);
  endfunction

  assign cycle_start = addr_vld && !vld_q;
  assign left        = cycle_start ? win_wait : cnt_q;
  assign ready_out   = (addr_vld && win_ign) ? (left == '0) : ext_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      vld_q <= addr_vld;
      cnt_q <= addr_vld ? step_down(left) : '0;
    end
  end
endmodule

// File: rtl/csd_decoder.sv
module csd_decoder import csd_pkg::*; #(
  parameter int ADDR_W = 20,
  parameter int GRAN_W = 10,
  parameter int NUM_GEN = 8,
  parameter int WAIT_W = 4,
  parameter int UCS_RST_WAIT = 3,
  localparam int BLK_W = ADDR_W - GRAN_W,
  localparam int NREG = NUM_GEN + 2,
  localparam int REG_W = BLK_W + WAIT_W + 2,
  localparam int ADR_W = $clog2(2 * NREG + 2)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADR_W-1:0]   wr_addr,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               addr_vld,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               is_io,
  input  logic               ext_ready,
  output logic               ucs_n,
  output logic               lcs_n,
  output logic [NUM_GEN-1:0] gcs_n,
  output logic               ready_out
);
  localparam int IDX_W = $clog2(NREG);

  logic [NREG-1:0][BLK_W-1:0]  base_q, end_q;
  logic [NREG-1:0][WAIT_W-1:0] wait_q;
  logic [NREG-1:0]             ign_q, en_q, io_q;
  logic [NUM_GEN-1:0]          pin_en_q, port_latch_q;
  logic [NREG-1:0]             hit, sel;
  logic [IDX_W-1:0]            win_idx;
  logic                        win_any, win_ign;
  logic [WAIT_W-1:0]           win_wait;
  logic                        addr_low_unused;

  assign addr_low_unused = ^addr[GRAN_W-1:0];

  csd_regs #(.NREG(NREG), .NUM_GEN(NUM_GEN), .REG_W(REG_W), .BLK_W(BLK_W),
             .WAIT_W(WAIT_W), .ADR_W(ADR_W), .UCS_RST_WAIT(UCS_RST_WAIT)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .base_q(base_q), .end_q(end_q), .wait_q(wait_q), .ign_q(ign_q),
    .en_q(en_q), .io_q(io_q), .pin_en_q(pin_en_q), .port_latch_q(port_latch_q)
  );

  csd_match #(.NREG(NREG), .BLK_W(BLK_W)) u_match (
    .addr_blk(addr[ADDR_W-1 -: BLK_W]), .is_io(is_io), .base_q(base_q),
    .end_q(end_q), .en_q(en_q), .io_q(io_q), .hit(hit)
  );

  csd_prio #(.N(NREG)) u_prio (
    .req(hit & {NREG{addr_vld}}), .grant(sel), .idx(win_idx), .any(win_any)
  );

  assign win_ign  = win_any && ign_q[win_idx];
  assign win_wait = wait_q[win_idx];

  csd_wait #(.WAIT_W(WAIT_W)) u_wait (
    .clk(clk), .rst(rst), .addr_vld(addr_vld), .win_ign(win_ign),
    .win_wait(win_wait), .ext_ready(ext_ready), .ready_out(ready_out)
  );

  assign ucs_n = ~sel[RGN_UPPER];
  assign lcs_n = ~sel[RGN_LOWER];

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_pin
    assign gcs_n[g] = pin_en_q[g] ? ~sel[RGN_GEN0 + g] : port_latch_q[g];
  end
endmodule

// File: rtl/csd_chk.sv
module csd_chk #(
  parameter int NREG = 10,
  parameter int WAIT_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              addr_vld,
  input logic              ready_out,
  input logic              win_ign,
  input logic [WAIT_W-1:0] win_wait,
  input logic [NREG-1:0]   hit,
  input logic [NREG-1:0]   sel
);
  a_r7_single_select: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel));

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !addr_vld |-> (sel == '0));

  for (genvar k = 0; k < NREG; k++) begin : g_k
    a_r8_sel_has_hit: assert property (@(posedge clk) disable iff (rst)
      sel[k] |-> hit[k]);
    if (k > 0) begin : g_lower
      a_r8_no_lower_hit: assert property (@(posedge clk) disable iff (rst)
        sel[k] |-> (hit[k-1:0] == '0));
    end
  end

  a_r10_first_cycle_waits: assert property (@(posedge clk) disable iff (rst)
    ($rose(addr_vld) && win_ign && (win_wait != '0)) |-> !ready_out);

  a_r10_ready_sticks: assert property (@(posedge clk) disable iff (rst)
    (addr_vld && win_ign && ready_out) |=> (!addr_vld || !win_ign || ready_out));
endmodule

bind csd_decoder csd_chk #(.NREG(NUM_GEN + 2), .WAIT_W(WAIT_W)) i_chk (
  .clk(clk), .rst(rst), .addr_vld(addr_vld), .ready_out(ready_out),
  .win_ign(win_ign), .win_wait(win_wait), .hit(hit), .sel(sel)
);

// File: tb/test_csd_decoder.sv
module test_csd_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        addr_vld = 1'b0;
  logic [19:0] addr = '0;
  logic        is_io = 1'b0;
  logic        ext_ready = 1'b0;
  logic        ucs_n, lcs_n, ready_out;
  logic [7:0]  gcs_n;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_start [10];
  logic [15:0] m_stop  [10];
  logic [7:0]  m_pen, m_lat;

  always #5 clk = ~clk;

  csd_decoder i_csd_decoder (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .addr_vld(addr_vld), .addr(addr), .is_io(is_io), .ext_ready(ext_ready),
    .ucs_n(ucs_n), .lcs_n(lcs_n), .gcs_n(gcs_n), .ready_out(ready_out)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // model of R2..R4: field positions per the register layout
  function automatic logic m_hit(input int r, input logic [19:0] a, input logic io);
    int blk, lo, hi, top;
    logic space;
    blk = int'(a[19:10]);
    lo  = int'(m_start[r][15:6]);
    hi  = int'(m_stop[r][15:6]);
    top = (hi == 0) ? 1024 : hi;
    space = (r < 2) ? !io : (io == m_stop[r][0]);
    return m_stop[r][1] && space && (blk >= lo) && (blk < top);
  endfunction

  function automatic int m_win(input logic [19:0] a, input logic io);
    for (int r = 0; r < 10; r++) if (m_hit(r, a, io)) return r;
    return -1;
  endfunction

  function automatic logic [7:0] m_pins(input int win);
    logic [7:0] p;
    for (int g = 0; g < 8; g++) p[g] = m_pen[g] ? (win != 2 + g) : m_lat[g];
    return p;
  endfunction

  task automatic check_bus(input string req, input int win, input logic rdy, input int left);
    logic exp_rdy;
    exp_rdy = (win >= 0 && m_start[win][4]) ? (left == 0) : rdy;
    chk(ucs_n === (win != 0), {req, " ucs_n"}, 32'(ucs_n), 32'(win != 0));
    chk(lcs_n === (win != 1), {req, " lcs_n"}, 32'(lcs_n), 32'(win != 1));
    chk(gcs_n === m_pins(win), {req, " gcs_n"}, 32'(gcs_n), 32'(m_pins(win)));
    chk(ready_out === exp_rdy, {req, " ready"}, 32'(ready_out), 32'(exp_rdy));
  endtask

  task automatic wreg(input int adr, input logic [15:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = 5'(adr); wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    if (adr < 20) begin
      if (adr % 2 == 0) m_start[adr / 2] = d; else m_stop[adr / 2] = d;
    end else if (adr == 20) m_pen = d[7:0];
    else m_lat = d[7:0];
  endtask

  task automatic bus(input logic [19:0] a, input logic io, input logic rdy);
    @(posedge clk); #1;
    addr_vld = 1'b1; addr = a; is_io = io; ext_ready = rdy;
    @(negedge clk);
  endtask

  task automatic idle(input string req);
    @(posedge clk); #1;
    addr_vld = 1'b0;
    @(negedge clk);
    check_bus(req, -1, ext_ready, 0);
  endtask

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL all requirements: watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [19:0] a;
    logic io, rdy;
    int win, left, pick;
    logic [31:0] rv;
    for (int r = 0; r < 10; r++) begin m_start[r] = '0; m_stop[r] = '0; end
    m_start[0] = 16'hFFC3;
    m_stop[0]  = 16'h0002;
    m_pen = 8'h00; m_lat = 8'hFF;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R5 R6: reset state, bus idle
    check_bus("R5 R6 reset idle", -1, 1'b0, 0);

    bus(20'hFFC00, 1'b0, 1'b1); check_bus("R5 upper low edge", 0, 1'b1, 3); idle("R6 idle");
    bus(20'hFFBFF, 1'b0, 1'b1); check_bus("R5 below upper window", -1, 1'b1, 0); idle("R6 idle");
    bus(20'hFFFFF, 1'b0, 1'b0); check_bus("R3 end zero reaches top", 0, 1'b0, 3); idle("R6 idle");
    bus(20'hFFC00, 1'b1, 1'b1); check_bus("R4 upper ignores io cycle", -1, 1'b1, 0); idle("R6 idle");

    // R1 R10: generic 3 (region 5), base block 0x100, end 0x101, ignore, 5 waits
    wreg(10, 16'h4015);
    wreg(11, 16'h4042);
    wreg(20, 16'h0008);
    @(posedge clk); #1;
    addr_vld = 1'b1; addr = 20'h40010; is_io = 1'b0; ext_ready = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(ready_out === (k >= 5), "R10 wait count", 32'(ready_out), 32'(k >= 5));
      chk(gcs_n === 8'hF7, "R1 R9 generic 3 asserted", 32'(gcs_n), 32'hF7);
    end
    idle("R6 idle");
    bus(20'h40010, 1'b0, 1'b0); check_bus("R12 count reloads", 5, 1'b0, 5); idle("R6 idle");
    bus(20'h40400, 1'b0, 1'b1); check_bus("R3 end exclusive", -1, 1'b1, 0); idle("R6 idle");
    bus(20'h3FFFF, 1'b0, 1'b0); check_bus("R3 below base", -1, 1'b0, 0); idle("R6 idle");
    wreg(10, 16'h4010);
    bus(20'h40010, 1'b0, 1'b0); check_bus("R10 zero waits", 5, 1'b0, 0); idle("R6 idle");
    wreg(10, 16'h4005);
    bus(20'h40010, 1'b0, 1'b0); check_bus("R11 pass low", 5, 1'b0, 5); idle("R6 idle");
    bus(20'h40010, 1'b0, 1'b1); check_bus("R11 pass high", 5, 1'b1, 5); idle("R6 idle");
    bus(20'h20000, 1'b0, 1'b1); check_bus("R11 no hit", -1, 1'b1, 0); idle("R6 idle");

    // R8: lower region overlaps generic 3, lower index wins
    wreg(2, 16'h3C00);
    wreg(3, 16'h4402);
    bus(20'h40010, 1'b0, 1'b0); check_bus("R7 R8 lower wins", 1, 1'b0, 0); idle("R6 idle");

    // R4 R9: generic 0 in I/O space
    wreg(4, 16'h4000);
    wreg(5, 16'h4043);
    wreg(20, 16'h0009);
    bus(20'h40010, 1'b1, 1'b1); check_bus("R4 generic io", 2, 1'b1, 0); idle("R6 idle");
    wreg(21, 16'h00A5);
    wreg(20, 16'h0000);
    bus(20'h40010, 1'b1, 1'b1); check_bus("R9 latch drives pins", 2, 1'b1, 0);
    chk(gcs_n === 8'hA5, "R9 latch value", 32'(gcs_n), 32'hA5);
    idle("R6 idle");
    wreg(1, 16'h0003);
    bus(20'hFFC00, 1'b1, 1'b0); check_bus("R4 upper io bit ignored", -1, 1'b0, 0); idle("R6 idle");
    bus(20'hFFC00, 1'b0, 1'b0); check_bus("R4 upper memory", 0, 1'b0, 3); idle("R6 idle");

    // random phase
    rv = $urandom(32'd20231);
    for (int it = 0; it < 400; it++) begin
      pick = $urandom_range(0, 9);
      rv = $urandom;
      if (pick < 5) wreg(2 * $urandom_range(0, 9) + $urandom_range(0, 1), rv[15:0]);
      else if (pick == 5) wreg(20 + $urandom_range(0, 1), rv[15:0]);
      rv = $urandom;
      if (rv[31]) a = {m_start[$urandom_range(0, 9)][15:6], rv[9:0]};
      else a = rv[19:0];
      io  = rv[30];
      rdy = rv[29];
      win = m_win(a, io);
      left = (win >= 0) ? int'(m_start[win][3:0]) : 0;
      bus(a, io, rdy);
      check_bus("R7 R8 R9 random", win, rdy, left);
      idle("R6 random idle");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule